// File: doc/BRIEF.md
# Iterative Wide Multiplier With High-Product Modes

This block multiplies two 64-bit register operands over a fixed number of clock cycles and returns one 64-bit result. A select input chooses what the result holds. It can be a 32-bit product that is sign-extended to 64 bits, the low 64 bits of the product, or the top half of the full 128-bit product. The top half can be taken with both operands signed, both unsigned, or the first signed and the second unsigned.

A one-cycle start strobe captures the operands and the select. The block then takes the magnitudes of the operands and builds their 128-bit product by accumulating several multiplier bits per cycle. It negates the product at the end if the signs require it. A one-cycle done strobe marks a valid result. The result stays on the output until the next job completes. A start that arrives while a job is running has no effect.

Top module: `wide_mul`

## Requirements
- R1: With mode 3'd2, the result is bits 127..64 of the product of the two operands, both read as two's-complement numbers.
- R2: With mode 3'd3, the result is bits 127..64 of the unsigned 128-bit product.
- R3: With mode 3'd4, the first operand is read as signed and the second as unsigned, and the result is bits 127..64 of their 128-bit product.
- R4: With mode 3'd0, the result is the product truncated to 32 bits, with bit 31 copied into bits 63..32. The upper halves of the operands do not affect it.
- R5: With mode 3'd1, the result is the product modulo 2^64.
- R6: A start pulse captures both operands and the mode only when no job is running. A start seen while a job runs is ignored and produces no extra done pulse.
- R7: done_o is high for exactly one cycle per accepted start. It rises XLEN/STEP_BITS+1 cycles after the clock edge that accepted the start, which is 33 cycles with the defaults.
- R8: result_o holds its value from one done pulse until the next done pulse.
- R9: After reset, done_o is 0 and result_o is 0.
- R10: With mode 3'd2, the most negative 64-bit value times itself yields 0x4000000000000000.
- R11: Mode codes 3'd5 to 3'd7 behave like mode 3'd1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a multiply |
| mode_i | input | 3 | Result select, encoded as listed in the requirements |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| result_o | output | 64 | Registered result |
| done_o | output | 1 | One-cycle valid strobe for result_o |

## Verification
The bench builds the block with XLEN of 64 and STEP_BITS of 2. With these values the radix-4 datapath and its 33-cycle latency are tested directly, and the bench can check every 128-bit corner against its own wide reference product. These corners include both extreme values, the most negative value squared, and mixed-sign high products. Because a job takes tens of cycles, there is room to fire a second start in the middle of a job and confirm that it leaves no trace.

// File: rtl/wide_mul_pkg.sv
package wide_mul_pkg;
  typedef logic [2:0] mul_mode_t;
  localparam mul_mode_t MODE_LO32  = 3'd0;
  localparam mul_mode_t MODE_LO64  = 3'd1;
  localparam mul_mode_t MODE_HI_SS = 3'd2;
  localparam mul_mode_t MODE_HI_UU = 3'd3;
  localparam mul_mode_t MODE_HI_SU = 3'd4;
endpackage

// File: rtl/wide_mul_prep.sv
module wide_mul_prep
  import wide_mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mul_mode_t         mode_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [XLEN-1:0]   mag_a_o,
  output logic [XLEN-1:0]   mag_b_o,
  output logic              neg_o
);
  logic a_signed, b_signed, a_neg, b_neg;

  always_comb begin
    a_signed = (mode_i == MODE_HI_SS) || (mode_i == MODE_HI_SU);
    b_signed = (mode_i == MODE_HI_SS);
    a_neg    = a_signed && a_i[XLEN-1];
    b_neg    = b_signed && b_i[XLEN-1];
    mag_a_o  = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b_o  = b_neg ? (~b_i + 1'b1) : b_i;
    neg_o    = a_neg ^ b_neg;
  end
endmodule

// File: rtl/wide_mul_core.sv
module wide_mul_core #(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [XLEN-1:0]   mag_a_i,
  input  logic [XLEN-1:0]   mag_b_i,
  output logic [2*XLEN-1:0] prod_o,
  output logic              fin_o
);
  localparam int PW    = 2 * XLEN;
  localparam int STEPS = XLEN / STEP_BITS;
  localparam int CW    = $clog2(STEPS + 1);

  logic [PW-1:0]   acc_q, mcand_q, pp;
  logic [XLEN-1:0] mplier_q;
  logic [CW-1:0]   cnt_q;
  logic            fin_q;

  generate
    if (STEP_BITS == 1) begin : g_radix2
      always_comb pp = mplier_q[0] ? mcand_q : '0;
    end else begin : g_radix_hi
      always_comb begin
        pp = '0;
        for (int k = 0; k < STEP_BITS; k++)
          if (mplier_q[k]) pp = pp + (mcand_q << k);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        acc_q    <= '0;
        mcand_q  <= {{XLEN{1'b0}}, mag_a_i};
        mplier_q <= mag_b_i;
        cnt_q    <= CW'(STEPS);
      end else if (cnt_q != '0) begin
        acc_q    <= acc_q + pp;
        mcand_q  <= mcand_q << STEP_BITS;
        mplier_q <= mplier_q >> STEP_BITS;
        cnt_q    <= cnt_q - 1'b1;
        fin_q    <= (cnt_q == CW'(1));
      end
    end
  end

  assign prod_o = acc_q;
  assign fin_o  = fin_q;

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |-> cnt_q == '0); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R7
  AST_FIN_AT_END: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> cnt_q == '0); // R7
endmodule

// File: rtl/wide_mul_fmt.sv
module wide_mul_fmt
  import wide_mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mul_mode_t          mode_i,
  input  logic               neg_i,
  input  logic [2*XLEN-1:0]  prod_i,
  output logic [XLEN-1:0]    res_o
);
  localparam int HALF = XLEN / 2;
  logic [2*XLEN-1:0] sp;

  always_comb begin
    sp = neg_i ? (~prod_i + 1'b1) : prod_i;
    case (mode_i)
      MODE_LO32:  res_o = {{(XLEN-HALF){sp[HALF-1]}}, sp[HALF-1:0]};
      MODE_HI_SS,
      MODE_HI_UU,
      MODE_HI_SU: res_o = sp[2*XLEN-1:XLEN];
      default:    res_o = sp[XLEN-1:0];
    endcase
  end
endmodule

// File: rtl/wide_mul.sv
module wide_mul
  import wide_mul_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0]   mag_a, mag_b, fmt_res, result_q;
  logic [2*XLEN-1:0] prod;
  logic              neg_w, neg_q, busy_q, done_q, fin, accept;
  mul_mode_t         mode_q;

  assign accept = start_i && !busy_q;

  wide_mul_prep #(.XLEN(XLEN)) i_prep (
    .mode_i (mode_i),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .mag_a_o(mag_a),
    .mag_b_o(mag_b),
    .neg_o  (neg_w)
  );

  wide_mul_core #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) i_core (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .mag_a_i(mag_a),
    .mag_b_i(mag_b),
    .prod_o (prod),
    .fin_o  (fin)
  );

  wide_mul_fmt #(.XLEN(XLEN)) i_fmt (
    .mode_i(mode_q),
    .neg_i (neg_q),
    .prod_i(prod),
    .res_o (fmt_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      neg_q    <= 1'b0;
      mode_q   <= MODE_LO32;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        neg_q  <= neg_w;
        mode_q <= mode_i;
      end else if (fin) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= fmt_res;
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(result_o)); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(mode_q) && $stable(neg_q))); // R6
  AST_LO32_SEXT: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MODE_LO32) |-> result_o[XLEN-1:HALF] == {(XLEN-HALF){result_o[HALF-1]}}); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !busy_q); // R7
endmodule

// File: tb/test_wide_mul.sv
module test_wide_mul;
  localparam int XLEN      = 64;
  localparam int STEP_BITS = 2;
  localparam int STEPS     = XLEN / STEP_BITS;

  typedef struct {
    logic [63:0] res;
    int          due;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic [63:0] result_o;
  logic        done_o;

  int   n_checks = 0, n_fail = 0, cyc = 0, n_done = 0;
  logic prev_done = 1'b0;
  exp_t q[$];

  wide_mul #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) i_wide_mul (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .result_o(result_o), .done_o(done_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m);
    logic [127:0] ea, eb, p;
    ea = {64'd0, a};
    eb = {64'd0, b};
    if (m == 3'd2 || m == 3'd4) ea = {{64{a[63]}}, a};
    if (m == 3'd2) eb = {{64{b[63]}}, b};
    p = ea * eb;
    case (m)
      3'd0:       return {{32{p[31]}}, p[31:0]};
      3'd2, 3'd3, 3'd4: return p[127:64];
      default:    return p[63:0];
    endcase
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o && prev_done) check(1'b0, "R7 done wider than one cycle", 64'd1, 64'd0);
      if (done_o) begin
        n_done++;
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected done", result_o, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(result_o === e.res, e.req, result_o, e.res);
          check(cyc == e.due, "R7 latency", 64'(cyc), 64'(e.due));
        end
      end
    end
    prev_done = done_o;
  end

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m, input string req);
    exp_t e;
    @(negedge clk);
    e.res = model(a, b, m);
    e.due = cyc + STEPS + 2;
    e.req = req;
    q.push_back(e);
    start_i = 1'b1; op_a_i = a; op_b_i = b; mode_i = m;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m, input string req);
    issue(a, b, m, req);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] lfsr_a, lfsr_b, last;
    int          dcount;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done_o === 1'b0, "R9 done after reset", 64'(done_o), 64'd0);
    check(result_o === 64'd0, "R9 result after reset", result_o, 64'd0);

    run_op(-64'sd3, 64'd5, 3'd2, "R1 small negative high");
    run_op(64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 3'd2, "R1 mixed extremes");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd3, "R2 max squared");
    run_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 3'd3, "R2 pattern");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, "R3 minus one times max");
    run_op(64'h7000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'd4, "R3 positive times large unsigned");
    run_op(64'hDEAD_BEEF_0001_0000, 64'hCAFE_F00D_0000_8000, 3'd0, "R4 bit31 set, upper halves ignored");
    run_op(64'hFFFF_0000_0000_0003, 64'h1111_0000_0000_0007, 3'd0, "R4 positive 32-bit");
    run_op(64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, 3'd1, "R5 low 64");
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'd2, "R10 most negative squared");
    check(result_o === 64'h4000_0000_0000_0000, "R10 direct value", result_o, 64'h4000_0000_0000_0000);
    run_op(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_0000_0002, 3'd6, "R11 unused mode acts as low 64");
    run_op(64'h0000_0000_0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, "R11 unused mode 7");

    // R8: result holds between done pulses
    last = result_o;
    repeat (12) @(negedge clk);
    check(result_o === last, "R8 result hold", result_o, last);

    // R6: second start mid-job is ignored
    dcount = n_done;
    issue(64'd7, 64'd9, 3'd1, "R6 first job survives");
    repeat (5) @(negedge clk);
    start_i = 1'b1; op_a_i = 64'hFFFF; op_b_i = 64'hFFFF; mode_i = 3'd3;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (STEPS + 6) @(negedge clk);
    check(n_done == dcount + 1, "R6 single done", 64'(n_done), 64'(dcount + 1));
    check(result_o === 64'd63, "R6 result kept", result_o, 64'd63);

    // mixed sweep over all modes
    lfsr_a = 64'hACE1_2468_1357_9BDF;
    lfsr_b = 64'h1F2E_3D4C_5B6A_7988;
    for (int i = 0; i < 24; i++) begin
      lfsr_a = {lfsr_a[62:0], lfsr_a[63] ^ lfsr_a[62] ^ lfsr_a[60] ^ lfsr_a[59]};
      lfsr_b = {lfsr_b[62:0], lfsr_b[63] ^ lfsr_b[62] ^ lfsr_b[60] ^ lfsr_b[59]};
      run_op(lfsr_a * 64'h9E37_79B9_7F4A_7C15, lfsr_b ^ (lfsr_a << 7), 3'(i % 8),
             "R1 R2 R3 R4 R5 R11 sweep");
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule